// File: doc/BRIEF.md
# Banked GPIO Controller with Edge Detection

This block is a memory-mapped general-purpose I/O controller for a pin count that is a multiple of 32, 64 by default. Software reaches it through a single-cycle 32-bit register port: a write strobe, a byte address and write data, with read data returned combinationally for whatever address is presented. The registers are grouped by feature. Each feature owns a bank of 32-bit words, and together those words cover every pin. The block drives an output latch vector, an output-enable vector and a 2-bit alternate-function select per pin. It also raises one combined interrupt line.

Pin inputs are synchronized through two flops before any use. The synchronized value is what software reads back as the pin level, and comparing it with its value one cycle earlier gives the edge events. Each pin can record rising edges, falling edges, or both, into a sticky status bit. Software clears that bit by writing a one to it. Outputs change only through write-one set and clear words, so two agents driving different pins never need a read-modify-write. The alternate-function bits are only stored and presented on a port, and the muxing they select lives outside the block.

Top module: `gpio_bank_ctrl`

## Requirements
- R1: After reset, every output is 0: output enables, output latches, alternate-function selects and the interrupt. All edge enables and all status bits read as 0.
- R2: The word index is the byte address divided by 4, and the two low address bits are ignored. With K = NPINS/32, feature f occupies word indices f*K to f*K+K-1. The features are numbered 0 level, 1 direction, 2 set, 3 clear, 4 rising enable, 5 falling enable, 6 status and 7 alternate function. In a one-bit-per-pin bank, pin p is bit p%32 of word f*K + p/32. The rising and falling enable banks read back what was written.
- R3: The level word returns the pin inputs after a two-flop synchronizer. A change presented before clock edge n is visible on reads from edge n+1 onward.
- R4: The direction bank is read/write. A bit of 1 makes the pin an output, and pin_oe equals the direction bits.
- R5: Writing the set bank turns on the output latch bit of every pin whose data bit is 1. Writing the clear bank turns those bits off. Data bits of 0 leave the latch unchanged, and pin_out equals the latch.
- R6: A pin with its rising enable set records a status bit on a 0-to-1 change of its synchronized level. The bit appears one edge after the change becomes visible on the level word.
- R7: A pin with its falling enable set records a 1-to-0 change in the same way. A pin with both enables set records either change, and a pin whose enable for that direction is clear records nothing.
- R8: Status bits are sticky. Writing 1 to a status bit clears it, and writing 0 leaves it unchanged. An edge recorded in the same cycle as a clear of that bit leaves the bit set.
- R9: irq is 1 exactly when at least one status bit is 1.
- R10: The alternate-function bank holds 2 bits per pin, 16 pins per word, in word indices 7*K to 9*K-1. Pin p sits in word 7*K + p/16 at bits 2*(p%16)+1:2*(p%16). alt_sel[2p+1:2p] presents that field.
- R11: Writes to the level word have no effect. The set and clear words read as 0, and any word index of 9*K or above reads as 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Write strobe for the word at bus_addr |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for bus_addr |
| pin_in | input | NPINS | Raw pin inputs |
| pin_out | output | NPINS | Output latch |
| pin_oe | output | NPINS | Output enable, 1 = drive |
| alt_sel | output | 2*NPINS | Alternate-function select, 2 bits per pin |
| irq | output | 1 | OR of all status bits |

## Verification
The sharpest corner is a status clear landing in the very cycle an edge on the same pin is recorded. A design that lets the clear win silently drops an event, and the bench times a write exactly onto that cycle to expose it. The bench also measures level and status latency to the cycle, so that a missing or extra synchronizer stage shows up as an off-by-one read. It exercises pins with only the opposite enable set, which a design that ignores direction would flag anyway. Finally, it walks the alternate-function bank, whose 16-pins-per-word layout breaks an index calculation copied from the one-bit banks, and reads the holes in the map along with the write-only words, which must return zero and not alias another bank.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

    localparam int WORD_W = 32;

    typedef enum logic [3:0] {
        FEAT_LEVEL = 4'd0,
        FEAT_DIR   = 4'd1,
        FEAT_SET   = 4'd2,
        FEAT_CLR   = 4'd3,
        FEAT_RISE  = 4'd4,
        FEAT_FALL  = 4'd5,
        FEAT_STAT  = 4'd6,
        FEAT_ALT   = 4'd7,
        FEAT_NONE  = 4'd15
    } feat_e;

endpackage

// File: rtl/gpio_addr_decode.sv
module gpio_addr_decode
    import gpio_bank_pkg::*;
#(
    parameter int NREG   = 2,
    parameter int ADDR_W = 7,
    parameter int IDX_W  = 2
) (
    input  logic [ADDR_W-1:0] addr,
    output feat_e             feat,
    output logic [IDX_W-1:0]  idx
);
    localparam int ALT_LO = 7 * NREG;
    localparam int ALT_HI = 9 * NREG;

    int w;

    always_comb begin
        w    = int'(addr[ADDR_W-1:2]);
        feat = FEAT_NONE;
        idx  = '0;
        if (w < ALT_LO) begin
            feat = feat_e'(4'(w / NREG));
            idx  = IDX_W'(w % NREG);
        end else if (w < ALT_HI) begin
            feat = FEAT_ALT;
            idx  = IDX_W'(w - ALT_LO);
        end
    end
endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
    parameter int NPINS = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NPINS-1:0] pin_in,
    output logic [NPINS-1:0] level,
    output logic [NPINS-1:0] level_prev
);
    typedef struct packed {
        logic s1;
        logic s2;
        logic prev;
    } stage_t;

    for (genvar p = 0; p < NPINS; p++) begin : g_pin
        stage_t st_d, st_q;

        always_comb begin
            st_d.s1   = pin_in[p];
            st_d.s2   = st_q.s1;
            st_d.prev = st_q.s2;
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) st_q <= '0;
            else        st_q <= st_d;
        end

        assign level[p]      = st_q.s2;
        assign level_prev[p] = st_q.prev;
    end
endmodule

// File: rtl/gpio_edge_status.sv
module gpio_edge_status #(
    parameter int NPINS = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NPINS-1:0] level,
    input  logic [NPINS-1:0] level_prev,
    input  logic [NPINS-1:0] rise_en,
    input  logic [NPINS-1:0] fall_en,
    input  logic [NPINS-1:0] clr_mask,
    output logic [NPINS-1:0] status
);
    logic [NPINS-1:0] events;
    logic [NPINS-1:0] status_d, status_q;

    always_comb begin
        events   = (level & ~level_prev & rise_en) | (~level & level_prev & fall_en);
        // a fresh event outranks a clear aimed at the same bit
        status_d = (status_q & ~clr_mask) | events;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) status_q <= '0;
        else        status_q <= status_d;
    end

    assign status = status_q;
endmodule

// File: rtl/gpio_bank_ctrl.sv
module gpio_bank_ctrl
    import gpio_bank_pkg::*;
#(
    parameter int  NPINS  = 64,
    localparam int NREG   = NPINS / 32,
    localparam int ADDR_W = $clog2(9 * NREG * 4)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bus_we,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [31:0]          bus_wdata,
    output logic [31:0]          bus_rdata,
    input  logic [NPINS-1:0]     pin_in,
    output logic [NPINS-1:0]     pin_out,
    output logic [NPINS-1:0]     pin_oe,
    output logic [2*NPINS-1:0]   alt_sel,
    output logic                 irq
);
    localparam int IDX_W = (2 * NREG > 1) ? $clog2(2 * NREG) : 1;
    localparam int NALT  = 2 * NREG;

    typedef struct packed {
        logic [NPINS-1:0]   dir;
        logic [NPINS-1:0]   out;
        logic [NPINS-1:0]   rise;
        logic [NPINS-1:0]   fall;
        logic [2*NPINS-1:0] alt;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    feat_e            feat;
    logic [IDX_W-1:0] idx;
    logic [NPINS-1:0] level, level_prev, status, clr_mask;

    gpio_addr_decode #(.NREG(NREG), .ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_dec (
        .addr (bus_addr),
        .feat (feat),
        .idx  (idx)
    );

    gpio_in_sync #(.NPINS(NPINS)) u_sync (
        .clk        (clk),
        .rst_n      (rst_n),
        .pin_in     (pin_in),
        .level      (level),
        .level_prev (level_prev)
    );

    gpio_edge_status #(.NPINS(NPINS)) u_stat (
        .clk        (clk),
        .rst_n      (rst_n),
        .level      (level),
        .level_prev (level_prev),
        .rise_en    (cfg_q.rise),
        .fall_en    (cfg_q.fall),
        .clr_mask   (clr_mask),
        .status     (status)
    );

    always_comb begin
        cfg_d    = cfg_q;
        clr_mask = '0;
        if (bus_we) begin
            for (int r = 0; r < NREG; r++) begin
                if (idx == IDX_W'(r)) begin
                    unique case (feat)
                        FEAT_DIR:  cfg_d.dir[r*32 +: 32]  = bus_wdata;
                        FEAT_SET:  cfg_d.out[r*32 +: 32]  = cfg_q.out[r*32 +: 32] | bus_wdata;
                        FEAT_CLR:  cfg_d.out[r*32 +: 32]  = cfg_q.out[r*32 +: 32] & ~bus_wdata;
                        FEAT_RISE: cfg_d.rise[r*32 +: 32] = bus_wdata;
                        FEAT_FALL: cfg_d.fall[r*32 +: 32] = bus_wdata;
                        FEAT_STAT: clr_mask[r*32 +: 32]   = bus_wdata;
                        default: ;
                    endcase
                end
            end
            for (int r = 0; r < NALT; r++) begin
                if (feat == FEAT_ALT && idx == IDX_W'(r)) begin
                    cfg_d.alt[r*32 +: 32] = bus_wdata;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    always_comb begin
        bus_rdata = '0;
        for (int r = 0; r < NREG; r++) begin
            if (idx == IDX_W'(r)) begin
                unique case (feat)
                    FEAT_LEVEL: bus_rdata = level[r*32 +: 32];
                    FEAT_DIR:   bus_rdata = cfg_q.dir[r*32 +: 32];
                    FEAT_RISE:  bus_rdata = cfg_q.rise[r*32 +: 32];
                    FEAT_FALL:  bus_rdata = cfg_q.fall[r*32 +: 32];
                    FEAT_STAT:  bus_rdata = status[r*32 +: 32];
                    default: ;
                endcase
            end
        end
        for (int r = 0; r < NALT; r++) begin
            if (feat == FEAT_ALT && idx == IDX_W'(r)) begin
                bus_rdata = cfg_q.alt[r*32 +: 32];
            end
        end
    end

    assign pin_out = cfg_q.out;
    assign pin_oe  = cfg_q.dir;
    assign alt_sel = cfg_q.alt;
    assign irq     = |status;
endmodule

// File: rtl/gpio_bank_ctrl_chk.sv
module gpio_bank_ctrl_chk #(
    parameter int  NPINS  = 64,
    localparam int NREG   = NPINS / 32,
    localparam int ADDR_W = $clog2(9 * NREG * 4)
) (
    input logic               clk,
    input logic               rst_n,
    input logic               bus_we,
    input logic [ADDR_W-1:0]  bus_addr,
    input logic [31:0]        bus_wdata,
    input logic [NPINS-1:0]   pin_out,
    input logic [NPINS-1:0]   pin_oe,
    input logic [2*NPINS-1:0] alt_sel,
    input logic               irq
);
    localparam logic [ADDR_W-3:0] SET_W0 = (ADDR_W-2)'(2 * NREG);
    localparam logic [ADDR_W-3:0] CLR_W0 = (ADDR_W-2)'(3 * NREG);

    assert_reset_state_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (pin_oe == '0 && pin_out == '0 && alt_sel == '0 && !irq));

    assert_set_high_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr[ADDR_W-1:2] == SET_W0 && bus_wdata[0]) |=> pin_out[0]);

    assert_clear_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr[ADDR_W-1:2] == CLR_W0 && bus_wdata[0]) |=> !pin_out[0]);

    assert_out_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_we |=> $stable(pin_out));

    assert_dir_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_we |=> $stable(pin_oe));

    assert_alt_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_we |=> $stable(alt_sel));

    assert_irq_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !bus_we) |=> irq);
endmodule

bind gpio_bank_ctrl gpio_bank_ctrl_chk #(.NPINS(NPINS)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .pin_out   (pin_out),
    .pin_oe    (pin_oe),
    .alt_sel   (alt_sel),
    .irq       (irq)
);

// File: tb/tb_gpio_bank_ctrl.sv
module tb_gpio_bank_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int NPINS  = 64;
    localparam int NREG   = NPINS / 32;
    localparam int ADDR_W = $clog2(9 * NREG * 4);
    localparam int MAXW   = 2 * NPINS;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic                 bus_we = 1'b0;
    logic [ADDR_W-1:0]    bus_addr = '0;
    logic [31:0]          bus_wdata = '0;
    logic [31:0]          bus_rdata;
    logic [NPINS-1:0]     pin_in = '0;
    logic [NPINS-1:0]     pin_out, pin_oe;
    logic [2*NPINS-1:0]   alt_sel;
    logic                 irq;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    bit started = 1'b0;
    bit done = 1'b0;

    gpio_bank_ctrl #(.NPINS(NPINS)) dut (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
        .pin_out(pin_out), .pin_oe(pin_oe), .alt_sel(alt_sel), .irq(irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // behavioural reference model
    logic [NPINS-1:0]   m_s1 = '0, m_s2 = '0, m_prev = '0;
    logic [NPINS-1:0]   m_dir = '0, m_out = '0, m_rise = '0, m_fall = '0, m_stat = '0;
    logic [2*NPINS-1:0] m_alt = '0;

    function automatic int word_addr(input int f, input int r);
        return f * NREG * 4 + r * 4;
    endfunction

    function automatic logic [31:0] model_read(input int a);
        int w = a / 4;
        int f, r;
        if (w >= 9 * NREG) return 32'h0;
        if (w >= 7 * NREG) return m_alt[(w - 7*NREG)*32 +: 32];
        f = w / NREG;
        r = w % NREG;
        case (f)
            0: return m_s2[r*32 +: 32];
            1: return m_dir[r*32 +: 32];
            4: return m_rise[r*32 +: 32];
            5: return m_fall[r*32 +: 32];
            6: return m_stat[r*32 +: 32];
            default: return 32'h0;
        endcase
    endfunction

    function automatic string read_req(input int a);
        int w = a / 4;
        if (w >= 9 * NREG) return "R11 unmapped";
        if (w >= 7 * NREG) return "R10 alt read";
        case (w / NREG)
            0: return "R3 level read";
            1: return "R4 dir read";
            2, 3: return "R11 set/clr read";
            6: return "R8 status read";
            default: return "R2 enable read";
        endcase
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_s1 <= '0; m_s2 <= '0; m_prev <= '0; m_dir <= '0; m_out <= '0;
            m_rise <= '0; m_fall <= '0; m_stat <= '0; m_alt <= '0;
        end else begin
            logic [NPINS-1:0] ev, clr;
            int w, f, r;
            ev  = (m_s2 & ~m_prev & m_rise) | (~m_s2 & m_prev & m_fall);
            clr = '0;
            w = int'(bus_addr) / 4;
            if (bus_we) begin
                if (w >= 7 * NREG && w < 9 * NREG) begin
                    m_alt[(w - 7*NREG)*32 +: 32] <= bus_wdata;
                end else if (w < 7 * NREG) begin
                    f = w / NREG;
                    r = w % NREG;
                    case (f)
                        1: m_dir[r*32 +: 32]  <= bus_wdata;
                        2: m_out[r*32 +: 32]  <= m_out[r*32 +: 32] | bus_wdata;
                        3: m_out[r*32 +: 32]  <= m_out[r*32 +: 32] & ~bus_wdata;
                        4: m_rise[r*32 +: 32] <= bus_wdata;
                        5: m_fall[r*32 +: 32] <= bus_wdata;
                        6: clr[r*32 +: 32] = bus_wdata;
                        default: ;
                    endcase
                end
            end
            m_stat <= (m_stat & ~clr) | ev;
            m_prev <= m_s2;
            m_s2   <= m_s1;
            m_s1   <= pin_in;
        end
    end

    task automatic chk(input string req, input logic [MAXW-1:0] act, input logic [MAXW-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    // per-cycle comparison against the model, away from the active edge
    always @(negedge clk) begin
        if (started && rst_n && !done) begin
            chk("R4 pin_oe", MAXW'(pin_oe), MAXW'(m_dir));
            chk("R5 pin_out", MAXW'(pin_out), MAXW'(m_out));
            chk("R10 alt_sel", MAXW'(alt_sel), MAXW'(m_alt));
            chk("R9 irq", MAXW'(irq), MAXW'(|m_stat));
            chk(read_req(int'(bus_addr)), MAXW'(bus_rdata), MAXW'(model_read(int'(bus_addr))));
        end
    end

    task automatic finish_run();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
            finish_run();
        end
    end

    task automatic step();
        @(negedge clk);
        #1;
    endtask

    task automatic wr(input int a, input logic [31:0] d);
        step();
        bus_we = 1'b1; bus_addr = ADDR_W'(a); bus_wdata = d;
        step();
        bus_we = 1'b0;
    endtask

    task automatic setaddr(input int a);
        bus_addr = ADDR_W'(a);
    endtask

    initial begin
        repeat (4) step();
        rst_n = 1'b1;
        started = 1'b1;
        step();
        // R1 reset state
        setaddr(word_addr(6, 0));
        chk("R1 oe", MAXW'(pin_oe), '0);
        chk("R1 out", MAXW'(pin_out), '0);
        chk("R1 alt", MAXW'(alt_sel), '0);
        chk("R1 irq", MAXW'(irq), '0);
        chk("R1 status", MAXW'(bus_rdata), '0);
        setaddr(word_addr(4, 1));
        #1 chk("R1 rise enable", MAXW'(bus_rdata), '0);

        // R4 direction
        wr(word_addr(1, 0), 32'h0000_00FF);
        wr(word_addr(1, 1), 32'h8000_0001);
        chk("R4 oe pattern", MAXW'(pin_oe), MAXW'({32'h8000_0001, 32'h0000_00FF}));

        // R5 set and clear
        wr(word_addr(2, 0), 32'h0000_F0F0);
        wr(word_addr(3, 0), 32'h0000_00F0);
        chk("R5 set/clear word0", MAXW'(pin_out[31:0]), MAXW'(32'h0000_F000));
        wr(word_addr(2, 1), 32'h8000_0000);
        wr(word_addr(3, 1), 32'h0000_0000);
        chk("R5 word1 zero-data clear", MAXW'(pin_out[63:32]), MAXW'(32'h8000_0000));

        // R11 level write ignored
        wr(word_addr(0, 0), 32'hFFFF_FFFF);
        #1 chk("R11 level write ignored", MAXW'(bus_rdata), '0);

        // R3 level latency
        setaddr(word_addr(0, 0));
        pin_in[5] = 1'b1;
        step();
        chk("R3 level after one edge", MAXW'(bus_rdata[5]), MAXW'(1'b0));
        step();
        chk("R3 level after two edges", MAXW'(bus_rdata[5]), MAXW'(1'b1));

        // R2 enable banks
        wr(word_addr(4, 0), 32'h0000_000F);
        wr(word_addr(5, 0), 32'h0010_000C);
        setaddr(word_addr(5, 0));
        #1 chk("R2 fall bank readback", MAXW'(bus_rdata), MAXW'(32'h0010_000C));

        // R6 rising, R7 fall-only pin ignores rise
        setaddr(word_addr(6, 0));
        pin_in[0] = 1'b1; pin_in[20] = 1'b1;
        repeat (3) step();
        chk("R6 rise recorded pin0", MAXW'(bus_rdata[0]), MAXW'(1'b1));
        chk("R7 rise ignored on fall-only pin20", MAXW'(bus_rdata[20]), MAXW'(1'b0));
        pin_in[0] = 1'b0; pin_in[20] = 1'b0;
        repeat (3) step();
        chk("R7 fall recorded pin20", MAXW'(bus_rdata[20]), MAXW'(1'b1));
        chk("R8 pin0 remains sticky", MAXW'(bus_rdata[0]), MAXW'(1'b1));
        chk("R9 irq with status", MAXW'(irq), MAXW'(1'b1));
        wr(word_addr(6, 0), 32'h0010_0001);
        chk("R8 W1C cleared", MAXW'(bus_rdata), '0);
        chk("R9 irq low", MAXW'(irq), '0);

        // R7 both enables on pin2
        pin_in[2] = 1'b1;
        repeat (3) step();
        chk("R7 both: rise on pin2", MAXW'(bus_rdata[2]), MAXW'(1'b1));
        wr(word_addr(6, 0), 32'h0000_0000);
        chk("R8 zero write keeps bit", MAXW'(bus_rdata[2]), MAXW'(1'b1));
        wr(word_addr(6, 0), 32'h0000_0004);
        pin_in[2] = 1'b0;
        repeat (3) step();
        chk("R7 both: fall on pin2", MAXW'(bus_rdata[2]), MAXW'(1'b1));
        wr(word_addr(6, 0), 32'h0000_0004);

        // R8 clear in the same cycle as a new edge on pin3
        pin_in[3] = 1'b1;
        step();
        wr(word_addr(6, 0), 32'h0000_0008);
        chk("R8 concurrent edge survives clear", MAXW'(bus_rdata[3]), MAXW'(1'b1));
        wr(word_addr(6, 0), 32'h0000_0008);
        chk("R8 later clear removes bit", MAXW'(bus_rdata[3]), MAXW'(1'b0));

        // R10 alternate-function packing
        wr(word_addr(7, 0) + 4, 32'h0000_000C);
        chk("R10 pin17 field", MAXW'(alt_sel[35:34]), MAXW'(2'b11));
        chk("R10 pin16 field", MAXW'(alt_sel[33:32]), MAXW'(2'b00));
        wr(word_addr(7, 0) + 12, 32'hC000_0000);
        chk("R10 pin63 field", MAXW'(alt_sel[127:126]), MAXW'(2'b11));

        // R11 unmapped and write-only reads
        for (int a = 9 * NREG * 4; a < (1 << ADDR_W); a += 4) begin
            setaddr(a);
            #1 chk("R11 unmapped read zero", MAXW'(bus_rdata), '0);
        end
        setaddr(word_addr(2, 0));
        #1 chk("R11 set reads zero", MAXW'(bus_rdata), '0);

        // mixed random traffic, compared every cycle against the model
        for (int i = 0; i < 600; i++) begin
            step();
            pin_in    = {$urandom, $urandom};
            bus_we    = ($urandom % 3) == 0;
            bus_addr  = ADDR_W'($urandom);
            bus_wdata = $urandom;
        end
        step();
        bus_we = 1'b0;
        repeat (4) step();
        finish_run();
    end
endmodule